// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers up to eight interrupt request lines from devices into a pending register. It combines that register with a software-programmed enable vector and drives one level-sensitive interrupt toward an upstream interrupt controller. The level is high whenever at least one pending bit is also enabled.

Software writes a mask byte. A 1 in the mask blocks a source, so the block keeps the bitwise inverse as its enable vector. Software drops a single pending bit by writing its number to the clear port, and it reads the whole pending register as a zero-extended 64-bit status word. Devices set pending bits with a set strobe and a bit vector, and remove them with a clear strobe and a bit vector.

A second, auxiliary mask byte can be written but is kept only as storage. Besides the level, the block gives the upstream controller a one-cycle post pulse when the level rises and a one-cycle withdraw pulse when the level falls.

Top module: `irq_aggregator`

## Requirements
- R1: A mask write stores the bitwise inverse of `mask_wdata` as the enable vector, so a 0 in mask bit i enables source i. The result is visible through `irq_level` after the clock edge that samples the write.
- R2: After every clock edge, `irq_level` equals the OR of (pending AND enable), taken from the values that edge stored. Any change to pending or enable shows on the level at that same edge.
- R3: A clear write removes the pending bit whose number is `clr_wdata[3:0]`. Bits 7:4 of `clr_wdata` are ignored. A number of 8 or more changes nothing.
- R4: A device set strobe ORs `dev_set_vec` into pending. Bits that are already pending stay pending.
- R5: A device clear strobe removes every pending bit that is 1 in `dev_clr_vec`. The level falls once no enabled pending bit remains.
- R6: When a set and a clear (device clear or clear write) name the same bit in the same cycle, the set wins and the bit stays pending.
- R7: `stat_rdata` always shows pending in bits 7:0, with bits 63:8 at zero.
- R8: An auxiliary mask write changes neither `irq_level` nor pending.
- R9: `post_pulse` is high for exactly the one cycle after the edge at which `irq_level` rose. `withdraw_pulse` is high for exactly the one cycle after the edge at which it fell. Neither pulse is high at any other time.
- R10: While `rst_n` is low at a clock edge, pending and enable are cleared and `irq_level`, `post_pulse` and `withdraw_pulse` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_we | input | 1 | Mask byte write strobe |
| mask_wdata | input | 8 | Mask byte (1 = blocked) |
| aux_mask_we | input | 1 | Auxiliary mask write strobe |
| aux_mask_wdata | input | 8 | Auxiliary mask byte (stored only) |
| clr_we | input | 1 | Clear-by-number write strobe |
| clr_wdata | input | 8 | Clear data; bits 3:0 give the bit number |
| dev_set_vld | input | 1 | Device set strobe |
| dev_set_vec | input | 8 | Bits to mark pending |
| dev_clr_vld | input | 1 | Device clear strobe |
| dev_clr_vec | input | 8 | Bits to remove from pending |
| stat_rdata | output | 64 | Pending register, zero-extended |
| irq_level | output | 1 | Level interrupt to the upstream controller |
| post_pulse | output | 1 | One-cycle pulse on a rising level |
| withdraw_pulse | output | 1 | One-cycle pulse on a falling level |

## Verification
The functions that can fall in the same cycle are the setting of a pending bit and its removal, whether by a device clear vector or by a software clear-by-number. The bench provokes both pairings. In one cycle it asserts a set strobe together with a clear write naming the same bit number; in another it asserts a set strobe together with a device clear vector covering the same bit. It then judges the status word and the level after that edge, and expects the bit still pending. A mask write arriving with a new request is also exercised, to confirm that the level and the post pulse reflect both updates at one edge.

// File: rtl/irq_agg_pkg.sv
// Package: shared types for the masked interrupt aggregator.
// Assumes: the clear-by-number command carries a 4-bit index field.
package irq_agg_pkg;

    localparam int unsigned CLR_IDX_W = 4;

    // Decoded clear-by-number command handed to the pending register
    typedef struct packed {
        logic                 vld;
        logic [CLR_IDX_W-1:0] idx;
    } clr_cmd_t;

endpackage

// File: rtl/irq_agg_pend.sv
// Module: pending register. It merges device set vectors, device clear
// vectors and a clear-by-number command. A set wins over any clear of the
// same bit in the same cycle.
// Assumes: synchronous active-low reset; index values >= N_SRC match no bit.
module irq_agg_pend
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [N_SRC-1:0] set_vec,
    input  logic             dclr_vld,
    input  logic [N_SRC-1:0] dclr_vec,
    input  clr_cmd_t         cmd,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] pend_d
);

    logic [N_SRC-1:0] num_hit;
    logic [N_SRC-1:0] set_eff;
    logic [N_SRC-1:0] drop_eff;

    // Decode the clear-by-number index into a one-hot drop vector
    for (genvar g = 0; g < N_SRC; g++) begin : g_dec
        assign num_hit[g] = cmd.vld && (32'(cmd.idx) == g);
    end

    // Gate the device vectors by their strobes
    always_comb begin
        set_eff  = set_vld  ? set_vec  : '0;
        drop_eff = (dclr_vld ? dclr_vec : '0) | num_hit;
        pend_d   = (pend_q & ~drop_eff) | set_eff;
    end

    // Hold the pending vector
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R4

    AST_NUM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.vld |=> ((pend_q & $past(num_hit & ~set_eff)) == '0)); // R3

    AST_DEV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        dclr_vld |=> ((pend_q & $past(dclr_vec & ~set_eff)) == '0)); // R5

endmodule

// File: rtl/irq_agg_mask.sv
// Module: mask storage. It keeps the inverse of the written mask as the
// enable vector, and keeps a separate auxiliary byte that feeds nothing
// downstream.
// Assumes: synchronous active-low reset; both registers reset to zero.
module irq_agg_mask #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             aux_we,
    input  logic [N_SRC-1:0] aux_wdata,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] en_d
);

    logic [N_SRC-1:0] aux_q;
    logic             aux_unused;

    // Next enable: the inverse of the written mask on a write, else hold
    always_comb en_d = mask_we ? ~mask_wdata : en_q;

    // Hold the enable vector
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Hold the auxiliary byte; it has no effect on the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n)      aux_q <= '0;
        else if (aux_we) aux_q <= aux_wdata;
    end

    assign aux_unused = ^aux_q;

    AST_MASK_INV: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (en_q == ~$past(mask_wdata))); // R1

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(en_q)); // R8

endmodule

// File: rtl/irq_agg_out.sv
// Module: output stage. It registers the level interrupt and produces
// one-cycle post and withdraw pulses when the level changes.
// Assumes: pend_d and en_d are the values stored at the same edge.
module irq_agg_out #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_d,
    input  logic [N_SRC-1:0] en_d,
    output logic             level_q,
    output logic             post_q,
    output logic             wdraw_q
);

    logic hit_d;

    // Any enabled pending source after this edge
    always_comb hit_d = |(pend_d & en_d);

    // Register the level and the edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            post_q  <= 1'b0;
            wdraw_q <= 1'b0;
        end else begin
            level_q <= hit_d;
            post_q  <= hit_d & ~level_q;
            wdraw_q <= ~hit_d & level_q;
        end
    end

    AST_POST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        post_q |-> (level_q && !$past(level_q))); // R9

    AST_WDRAW_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wdraw_q |-> (!level_q && $past(level_q))); // R9

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(post_q && wdraw_q)); // R9

endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the masked interrupt aggregator. It decodes the
// clear-by-number write, wires the pending, mask and output stages, and
// zero-extends pending onto the status word.
// Assumes: STAT_W >= N_SRC; synchronous active-low reset.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned STAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [N_SRC-1:0]  mask_wdata,
    input  logic              aux_mask_we,
    input  logic [N_SRC-1:0]  aux_mask_wdata,
    input  logic              clr_we,
    input  logic [7:0]        clr_wdata,
    input  logic              dev_set_vld,
    input  logic [N_SRC-1:0]  dev_set_vec,
    input  logic              dev_clr_vld,
    input  logic [N_SRC-1:0]  dev_clr_vec,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_level,
    output logic              post_pulse,
    output logic              withdraw_pulse
);

    clr_cmd_t         clr_cmd;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] pend_d;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] en_d;
    logic [3:0]       clr_hi_unused;

    // Take the bit number from the low nibble; the upper nibble is ignored
    always_comb begin
        clr_cmd.vld = clr_we;
        clr_cmd.idx = clr_wdata[CLR_IDX_W-1:0];
    end
    assign clr_hi_unused = clr_wdata[7:4];

    irq_agg_pend #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (dev_set_vld),
        .set_vec  (dev_set_vec),
        .dclr_vld (dev_clr_vld),
        .dclr_vec (dev_clr_vec),
        .cmd      (clr_cmd),
        .pend_q   (pend_q),
        .pend_d   (pend_d)
    );

    irq_agg_mask #(.N_SRC(N_SRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .aux_we     (aux_mask_we),
        .aux_wdata  (aux_mask_wdata),
        .en_q       (en_q),
        .en_d       (en_d)
    );

    irq_agg_out #(.N_SRC(N_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_d  (pend_d),
        .en_d    (en_d),
        .level_q (irq_level),
        .post_q  (post_pulse),
        .wdraw_q (withdraw_pulse)
    );

    // Zero-extend pending onto the wide status word
    always_comb stat_rdata = STAT_W'(pend_q);

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == |(pend_q & en_q)); // R2

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[STAT_W-1:N_SRC] == '0); // R7

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_we = 0, aux_mask_we = 0, clr_we = 0;
    logic        dev_set_vld = 0, dev_clr_vld = 0;
    logic [7:0]  mask_wdata = 0, aux_mask_wdata = 0, clr_wdata = 0;
    logic [7:0]  dev_set_vec = 0, dev_clr_vec = 0;
    logic [63:0] stat_rdata;
    logic        irq_level, post_pulse, withdraw_pulse;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_pend = 0;
    logic [7:0] exp_en = 0;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .aux_mask_we(aux_mask_we), .aux_mask_wdata(aux_mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .dev_set_vld(dev_set_vld), .dev_set_vec(dev_set_vec),
        .dev_clr_vld(dev_clr_vld), .dev_clr_vec(dev_clr_vec),
        .stat_rdata(stat_rdata), .irq_level(irq_level),
        .post_pulse(post_pulse), .withdraw_pulse(withdraw_pulse)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply the driven strobes for one edge, sample after it, drop strobes
    task automatic step();
        @(posedge clk);
        #1;
        mask_we = 0; aux_mask_we = 0; clr_we = 0;
        dev_set_vld = 0; dev_clr_vld = 0;
    endtask

    task automatic chk_all(input string req, input logic post_e, input logic wd_e);
        chk({req, " stat"}, stat_rdata, {56'd0, exp_pend});
        chk({req, " level"}, {63'd0, irq_level}, {63'd0, |(exp_pend & exp_en)});
        chk({req, " post"}, {63'd0, post_pulse}, {63'd0, post_e});
        chk({req, " withdraw"}, {63'd0, withdraw_pulse}, {63'd0, wd_e});
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 0;
        step();
        exp_pend = 0; exp_en = 0;
        chk_all("R10", 0, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_set_masked();
        @(negedge clk); dev_set_vld = 1; dev_set_vec = 8'h05;
        step(); exp_pend = 8'h05;
        chk_all("R4 R7 masked", 0, 0);
    endtask

    task automatic t_mask_enable();
        @(negedge clk); mask_we = 1; mask_wdata = 8'hFE;
        step(); exp_en = 8'h01;
        chk_all("R1 R2 R9 rise", 1, 0);
        @(negedge clk); step();
        chk_all("R9 post one cycle", 0, 0);
    endtask

    task automatic t_aux_mask();
        @(negedge clk); aux_mask_we = 1; aux_mask_wdata = 8'hFF;
        step();
        chk_all("R8 aux mask", 0, 0);
    endtask

    task automatic t_clr_num();
        @(negedge clk); clr_we = 1; clr_wdata = 8'hF0;
        step(); exp_pend = 8'h04;
        chk_all("R3 R9 fall", 0, 1);
        @(negedge clk); clr_we = 1; clr_wdata = 8'h0A;
        step();
        chk_all("R3 index over range", 0, 0);
    endtask

    task automatic t_dev_clr();
        @(negedge clk); mask_we = 1; mask_wdata = 8'hFB;
        step(); exp_en = 8'h04;
        chk_all("R1 R2 re-enable", 1, 0);
        @(negedge clk); dev_clr_vld = 1; dev_clr_vec = 8'h0C;
        step(); exp_pend = 8'h00;
        chk_all("R5 device clear", 0, 1);
    endtask

    task automatic t_collide();
        @(negedge clk); dev_set_vld = 1; dev_set_vec = 8'h08;
        clr_we = 1; clr_wdata = 8'h03;
        step(); exp_pend = 8'h08;
        chk_all("R6 set vs clear write", 0, 0);
        @(negedge clk); dev_set_vld = 1; dev_set_vec = 8'h10;
        dev_clr_vld = 1; dev_clr_vec = 8'h18;
        step(); exp_pend = 8'h10;
        chk_all("R6 set vs device clear", 0, 0);
    endtask

    task automatic t_busy_level();
        @(negedge clk); mask_we = 1; mask_wdata = 8'h00;
        dev_set_vld = 1; dev_set_vec = 8'h80;
        step(); exp_en = 8'hFF; exp_pend = 8'h90;
        chk_all("R2 R9 mask and set together", 1, 0);
        @(negedge clk); dev_set_vld = 1; dev_set_vec = 8'h01;
        step(); exp_pend = 8'h91;
        chk_all("R9 no repost while high", 0, 0);
        @(negedge clk); mask_we = 1; mask_wdata = 8'hFF;
        step(); exp_en = 8'h00;
        chk_all("R1 mask all", 0, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_set_masked();
                t_mask_enable();
                t_aux_mask();
                t_clr_num();
                t_dev_clr();
                t_collide();
                t_busy_level();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule